// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of a NOR-style parallel flash that takes unlock-and-command write patterns. A client hands it one request at a time: program a word, erase the sector holding an address, erase the whole device, or fetch the two identification words. The block sends the write pattern for that request over a simple request/acknowledge flash bus. It then polls the device until the operation finishes and raises a one-cycle completion strobe with an error flag.

Completion is detected from the data bus alone. While an internal operation runs, the device flips data bit 6 on every read. The sequencer keeps reading until two reads in a row agree on that bit. A poll budget guards against a device that never settles; when it runs out, the device is sent its reset command and the request ends with an error. After a program operation the word is read back and compared with the requested value.

Top module: `flash_cmd_seq`

## Requirements
- R1: Operation code 0 (program) produces exactly four bus writes: 0xAA at unlock address 0, 0x55 at unlock address 1, 0xA0 at unlock address 0, then the request data at the request address.
- R2: Operation code 1 (sector erase) produces exactly six bus writes: 0xAA@U0, 0x55@U1, 0x80@U0, 0xAA@U0, 0x55@U1, then 0x30 at the request address.
- R3: Operation code 2 (chip erase) produces the same first five writes as R2, and the sixth is 0x10 at unlock address 0.
- R4: Operation code 3 (identify) writes 0xAA@U0, 0x55@U1 and 0x90@U0, reads word addresses 0 and 1 into id_word0 and id_word1, then writes 0xF0 at unlock address 0, with err low.
- R5: After the last command write of a program or erase, the block reads the request address repeatedly and stops after the first read whose bit 6 equals bit 6 of the read just before it.
- R6: If TIMEOUT_POLLS poll reads pass without two equal consecutive bit-6 values, the block writes 0xF0 at unlock address 0, then ends the request with err high.
- R7: req_ready is high only while the block is idle; req_valid asserted while busy starts no bus activity and is not queued.
- R8: A completed program reads back the request address once; err is high exactly when that value differs from the request data; a new request clears err.
- R9: Out of reset, req_ready is high and done, err and fl_req are low.
- R10: done is a single-cycle pulse; err and the identification words are valid in that cycle and held until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 identify |
| req_addr | input | ADDR_W | Target word address |
| req_data | input | DATA_W | Word to program |
| done | output | 1 | One-cycle end-of-request strobe |
| err | output | 1 | Timeout or readback mismatch on the last request |
| id_word0 | output | DATA_W | Identification word at offset 0 |
| id_word1 | output | DATA_W | Identification word at offset 1 |
| fl_req | output | 1 | Flash bus access request, held until acknowledged |
| fl_we | output | 1 | Access is a write |
| fl_addr | output | ADDR_W | Flash word address |
| fl_wdata | output | DATA_W | Flash write data |
| fl_ack | input | 1 | Access finished; fl_rdata valid for reads |
| fl_rdata | input | DATA_W | Flash read data |

## Verification
A wrong step index or step table entry shows up on the flash bus at the very next access, as a bad address or command byte. The bench catches it by comparing the whole write log of each request with the expected pattern. A poll monitor that samples or compares bit 6 wrongly makes the read count differ from the first equal pair in the returned bit-6 sequence. A broken timeout counter either never aborts a stuck device or aborts early, and the bench sees this as a wrong read count before the 0xF0 write. A stale error flag or identification register shows at the first done strobe after the fault.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROGRAM    = 2'd0,
        OP_SECT_ERASE = 2'd1,
        OP_CHIP_ERASE = 2'd2,
        OP_READ_ID    = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_WRITE,
        ST_RD_ID0,
        ST_RD_ID1,
        ST_POLL,
        ST_VERIFY,
        ST_END
    } step_e;

    typedef enum logic [1:0] {
        AS_UNLOCK0,
        AS_UNLOCK1,
        AS_TARGET,
        AS_BASE
    } asel_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_ABORT
    } seq_state_e;

    typedef struct packed {
        step_e       kind;
        asel_e       asel;
        logic        use_data;
        logic [7:0]  code;
    } step_t;

    localparam int STEP_IDX_W = 4;

    localparam logic [7:0] CMD_UNLOCK_A    = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B    = 8'h55;
    localparam logic [7:0] CMD_PROGRAM     = 8'hA0;
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h80;
    localparam logic [7:0] CMD_AUTOSELECT  = 8'h90;
    localparam logic [7:0] CMD_SECTOR      = 8'h30;
    localparam logic [7:0] CMD_CHIP        = 8'h10;
    localparam logic [7:0] CMD_RESET       = 8'hF0;

    function automatic step_t mk_step(step_e k, asel_e s, logic u, logic [7:0] c);
        step_t t;
        t.kind     = k;
        t.asel     = s;
        t.use_data = u;
        t.code     = c;
        return t;
    endfunction

endpackage

// File: rtl/fseq_step_table.sv
module fseq_step_table
    import flash_seq_pkg::*;
#(
    parameter int                  ADDR_W  = 20,
    parameter int                  DATA_W  = 16,
    parameter logic [ADDR_W-1:0]   UNLOCK0 = 'h555,
    parameter logic [ADDR_W-1:0]   UNLOCK1 = 'h2AA
) (
    input  op_e                    op,
    input  logic [STEP_IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0]      tgt_addr,
    input  logic [DATA_W-1:0]      tgt_data,
    output step_e                  kind,
    output logic [ADDR_W-1:0]      addr,
    output logic [DATA_W-1:0]      wdata
);

    step_t st;

    always_comb begin
        st = mk_step(ST_END, AS_BASE, 1'b0, 8'h00);
        case (op)
            OP_PROGRAM: begin
                case (idx)
                    4'd0: st = mk_step(ST_WRITE,  AS_UNLOCK0, 1'b0, CMD_UNLOCK_A);
                    4'd1: st = mk_step(ST_WRITE,  AS_UNLOCK1, 1'b0, CMD_UNLOCK_B);
                    4'd2: st = mk_step(ST_WRITE,  AS_UNLOCK0, 1'b0, CMD_PROGRAM);
                    4'd3: st = mk_step(ST_WRITE,  AS_TARGET,  1'b1, 8'h00);
                    4'd4: st = mk_step(ST_POLL,   AS_TARGET,  1'b0, 8'h00);
                    4'd5: st = mk_step(ST_VERIFY, AS_TARGET,  1'b0, 8'h00);
                    default: ;
                endcase
            end
            OP_SECT_ERASE, OP_CHIP_ERASE: begin
                case (idx)
                    4'd0: st = mk_step(ST_WRITE, AS_UNLOCK0, 1'b0, CMD_UNLOCK_A);
                    4'd1: st = mk_step(ST_WRITE, AS_UNLOCK1, 1'b0, CMD_UNLOCK_B);
                    4'd2: st = mk_step(ST_WRITE, AS_UNLOCK0, 1'b0, CMD_ERASE_SETUP);
                    4'd3: st = mk_step(ST_WRITE, AS_UNLOCK0, 1'b0, CMD_UNLOCK_A);
                    4'd4: st = mk_step(ST_WRITE, AS_UNLOCK1, 1'b0, CMD_UNLOCK_B);
                    4'd5: st = (op == OP_SECT_ERASE)
                             ? mk_step(ST_WRITE, AS_TARGET,  1'b0, CMD_SECTOR)
                             : mk_step(ST_WRITE, AS_UNLOCK0, 1'b0, CMD_CHIP);
                    4'd6: st = mk_step(ST_POLL,  AS_TARGET,  1'b0, 8'h00);
                    default: ;
                endcase
            end
            OP_READ_ID: begin
                case (idx)
                    4'd0: st = mk_step(ST_WRITE,  AS_UNLOCK0, 1'b0, CMD_UNLOCK_A);
                    4'd1: st = mk_step(ST_WRITE,  AS_UNLOCK1, 1'b0, CMD_UNLOCK_B);
                    4'd2: st = mk_step(ST_WRITE,  AS_UNLOCK0, 1'b0, CMD_AUTOSELECT);
                    4'd3: st = mk_step(ST_RD_ID0, AS_BASE,    1'b0, 8'h00);
                    4'd4: st = mk_step(ST_RD_ID1, AS_BASE,    1'b0, 8'h01);
                    4'd5: st = mk_step(ST_WRITE,  AS_UNLOCK0, 1'b0, CMD_RESET);
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    always_comb begin
        kind = st.kind;
        case (st.asel)
            AS_UNLOCK0: addr = UNLOCK0;
            AS_UNLOCK1: addr = UNLOCK1;
            AS_TARGET:  addr = tgt_addr;
            default:    addr = ADDR_W'(st.code);
        endcase
        wdata = st.use_data ? tgt_data : DATA_W'(st.code);
    end

endmodule

// File: rtl/fseq_toggle_mon.sv
module fseq_toggle_mon #(
    parameter int TIMEOUT_POLLS = 4096,
    localparam int CNT_W = $clog2(TIMEOUT_POLLS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic bit6,
    output logic stable,
    output logic expired
);

    typedef struct packed {
        logic             have_prev;
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } mon_t;

    mon_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        stable  = sample && r_q.have_prev && (bit6 == r_q.prev);
        expired = sample && !stable && (r_q.cnt == CNT_W'(TIMEOUT_POLLS - 1));
        if (clear) begin
            r_d = '0;
        end else if (sample) begin
            r_d.have_prev = 1'b1;
            r_d.prev      = bit6;
            r_d.cnt       = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_POLL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CNT_W'(TIMEOUT_POLLS)); // R6

    AST_STABLE_AFTER_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        stable |-> (r_q.cnt != '0)); // R5

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int                ADDR_W        = 20,
    parameter int                DATA_W        = 16,
    parameter logic [ADDR_W-1:0] UNLOCK0_ADDR  = 'h555,
    parameter logic [ADDR_W-1:0] UNLOCK1_ADDR  = 'h2AA,
    parameter int                TIMEOUT_POLLS = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] id_word0,
    output logic [DATA_W-1:0] id_word1,
    output logic              fl_req,
    output logic              fl_we,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic              fl_ack,
    input  logic [DATA_W-1:0] fl_rdata
);

    localparam int POLL_BIT = 6;

    typedef struct packed {
        seq_state_e              state;
        op_e                     op;
        logic [ADDR_W-1:0]       addr;
        logic [DATA_W-1:0]       data;
        logic [STEP_IDX_W-1:0]   idx;
        logic                    err;
        logic                    done;
        logic [DATA_W-1:0]       id0;
        logic [DATA_W-1:0]       id1;
    } seq_t;

    seq_t r_q, r_d;

    step_e             step_kind;
    logic [ADDR_W-1:0] step_addr;
    logic [DATA_W-1:0] step_wdata;
    logic              mon_clear, mon_sample, poll_stable, poll_expired;

    fseq_step_table #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .UNLOCK0 (UNLOCK0_ADDR),
        .UNLOCK1 (UNLOCK1_ADDR)
    ) i_table (
        .op       (r_q.op),
        .idx      (r_q.idx),
        .tgt_addr (r_q.addr),
        .tgt_data (r_q.data),
        .kind     (step_kind),
        .addr     (step_addr),
        .wdata    (step_wdata)
    );

    fseq_toggle_mon #(
        .TIMEOUT_POLLS (TIMEOUT_POLLS)
    ) i_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (mon_clear),
        .sample  (mon_sample),
        .bit6    (fl_rdata[POLL_BIT]),
        .stable  (poll_stable),
        .expired (poll_expired)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        mon_clear  = 1'b0;
        mon_sample = (r_q.state == SQ_RUN) && (step_kind == ST_POLL) && fl_ack;

        case (r_q.state)
            SQ_IDLE: begin
                if (req_valid) begin
                    r_d.state = SQ_RUN;
                    r_d.op    = op_e'(req_op);
                    r_d.addr  = req_addr;
                    r_d.data  = req_data;
                    r_d.idx   = '0;
                    r_d.err   = 1'b0;
                    mon_clear = 1'b1;
                end
            end
            SQ_RUN: begin
                if (step_kind == ST_END) begin
                    r_d.state = SQ_IDLE;
                    r_d.done  = 1'b1;
                end else if (fl_ack) begin
                    case (step_kind)
                        ST_RD_ID0: begin
                            r_d.id0 = fl_rdata;
                            r_d.idx = r_q.idx + 1'b1;
                        end
                        ST_RD_ID1: begin
                            r_d.id1 = fl_rdata;
                            r_d.idx = r_q.idx + 1'b1;
                        end
                        ST_POLL: begin
                            if (poll_stable) begin
                                r_d.idx = r_q.idx + 1'b1;
                            end else if (poll_expired) begin
                                r_d.state = SQ_ABORT;
                                r_d.err   = 1'b1;
                            end
                        end
                        ST_VERIFY: begin
                            if (fl_rdata != r_q.data) r_d.err = 1'b1;
                            r_d.idx = r_q.idx + 1'b1;
                        end
                        default: r_d.idx = r_q.idx + 1'b1;
                    endcase
                end
            end
            SQ_ABORT: begin
                if (fl_ack) begin
                    r_d.state = SQ_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= SQ_IDLE;
            r_q.op    <= OP_PROGRAM;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_ready = (r_q.state == SQ_IDLE);
        done      = r_q.done;
        err       = r_q.err;
        id_word0  = r_q.id0;
        id_word1  = r_q.id1;
        if (r_q.state == SQ_ABORT) begin
            fl_req   = 1'b1;
            fl_we    = 1'b1;
            fl_addr  = UNLOCK0_ADDR;
            fl_wdata = DATA_W'(CMD_RESET);
        end else begin
            fl_req   = (r_q.state == SQ_RUN) && (step_kind != ST_END);
            fl_we    = (step_kind == ST_WRITE);
            fl_addr  = step_addr;
            fl_wdata = step_wdata;
        end
    end

    AST_ACCEPT_STARTS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (fl_req && !req_ready)); // R7

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr) && $stable(fl_we)
                                 && $stable(fl_wdata))); // R1

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !fl_req)); // R10

    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !err); // R8

endmodule

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;

    localparam logic [19:0] U0 = 20'h00555;
    localparam logic [19:0] U1 = 20'h002AA;
    localparam int TMO = 12;
    localparam logic [15:0] ID0 = 16'h00C2;
    localparam logic [15:0] ID1 = 16'h22DA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic        done, err;
    logic [15:0] id_word0, id_word1;
    logic        fl_req, fl_we;
    logic [19:0] fl_addr;
    logic [15:0] fl_wdata;
    logic        fl_ack;
    logic [15:0] fl_rdata;

    flash_cmd_seq #(
        .ADDR_W(20), .DATA_W(16), .UNLOCK0_ADDR(U0), .UNLOCK1_ADDR(U1),
        .TIMEOUT_POLLS(TMO)
    ) i_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .done(done),
        .err(err), .id_word0(id_word0), .id_word1(id_word1), .fl_req(fl_req),
        .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_ack(fl_ack),
        .fl_rdata(fl_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- flash device model ----------------
    logic [15:0] mem [256];
    logic        ack_q = 1'b0;
    logic [15:0] rdata_q = '0;
    int          busy = 0;
    int          busy_len = 0;
    bit          tog = 0;
    int          mstate = 0;
    bit          idmode = 0;
    int          wcnt = 0;
    int          rcnt = 0;
    logic [19:0] wla [16];
    logic [15:0] wld [16];
    logic [15:0] rld [64];

    assign fl_ack   = ack_q;
    assign fl_rdata = rdata_q;

    task automatic m_write(input logic [19:0] a, input logic [15:0] d);
        if (wcnt < 16) begin wla[wcnt] = a; wld[wcnt] = d; end
        wcnt++;
        if (d == 16'h00F0 && mstate != 3) begin
            mstate = 0; idmode = 0; busy = 0;
            return;
        end
        if (busy > 0) return;
        case (mstate)
            0: mstate = (a == U0 && d == 16'h00AA) ? 1 : 0;
            1: mstate = (a == U1 && d == 16'h0055) ? 2 : 0;
            2: begin
                mstate = 0;
                if (a == U0) begin
                    if (d == 16'h00A0) mstate = 3;
                    else if (d == 16'h0080) mstate = 4;
                    else if (d == 16'h0090) idmode = 1;
                end
            end
            3: begin mem[a[7:0]] = mem[a[7:0]] & d; busy = busy_len; mstate = 0; end
            4: mstate = (a == U0 && d == 16'h00AA) ? 5 : 0;
            5: mstate = (a == U1 && d == 16'h0055) ? 6 : 0;
            6: begin
                mstate = 0;
                if (d == 16'h0030) begin
                    for (int i = 0; i < 16; i++) mem[{a[7:4], 4'(i)}] = 16'hFFFF;
                    busy = busy_len;
                end else if (d == 16'h0010 && a == U0) begin
                    for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
                    busy = busy_len;
                end
            end
            default: mstate = 0;
        endcase
    endtask

    function automatic logic [15:0] m_read(input logic [19:0] a);
        logic [15:0] v;
        if (busy > 0) begin
            tog = ~tog;
            v = {9'd0, tog, 6'd0};
            busy--;
        end else if (idmode && a == 20'd0) v = ID0;
        else if (idmode && a == 20'd1) v = ID1;
        else v = mem[a[7:0]];
        if (rcnt < 64) rld[rcnt] = v;
        rcnt++;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h03A7) ^ 16'h5C31;
        end else if (fl_req && !ack_q) begin
            ack_q <= 1'b1;
            if (fl_we) m_write(fl_addr, fl_wdata);
            else rdata_q <= m_read(fl_addr);
        end else begin
            ack_q <= 1'b0;
        end
    end

    // ---------------- expected behaviour ----------------
    logic [19:0] ew_a [8];
    logic [15:0] ew_d [8];
    int en;

    task automatic set_exp(input logic [1:0] op, input logic [19:0] a, input logic [15:0] d);
        ew_a[0] = U0; ew_d[0] = 16'h00AA;
        ew_a[1] = U1; ew_d[1] = 16'h0055;
        ew_a[2] = U0;
        case (op)
            2'd0: begin ew_d[2] = 16'h00A0; ew_a[3] = a; ew_d[3] = d; en = 4; end
            2'd3: begin ew_d[2] = 16'h0090; ew_a[3] = U0; ew_d[3] = 16'h00F0; en = 4; end
            default: begin
                ew_d[2] = 16'h0080;
                ew_a[3] = U0; ew_d[3] = 16'h00AA;
                ew_a[4] = U1; ew_d[4] = 16'h0055;
                if (op == 2'd1) begin ew_a[5] = a; ew_d[5] = 16'h0030; end
                else begin ew_a[5] = U0; ew_d[5] = 16'h0010; end
                en = 6;
            end
        endcase
    endtask

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic wait_done();
        int n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        chk(done == 1'b1, "R10", "done seen before limit", longint'(done), 1);
    endtask

    task automatic run_op(input logic [1:0] op, input logic [19:0] a,
                          input logic [15:0] d, input int bl);
        bit tmo = (bl >= 1000) && (op != 2'd3);
        bit exp_err = 0;
        int n;
        bit early;
        string tag = op_tag(op);
        if (op == 2'd0 && !tmo) exp_err = ((mem[a[7:0]] & d) != d);
        if (tmo) exp_err = 1;
        busy_len = bl; wcnt = 0; rcnt = 0;
        set_exp(op, a, d);
        if (tmo) begin ew_a[en] = U0; ew_d[en] = 16'h00F0; en++; end
        @(negedge clk);
        chk(req_ready == 1'b1, "R7", "ready while idle", longint'(req_ready), 1);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R7", "ready dropped once busy", longint'(req_ready), 0);
        wait_done();
        chk(err == exp_err, tmo ? "R6" : (op == 2'd0 ? "R8" : tag), "err at done",
            longint'(err), longint'(exp_err));
        chk(wcnt == en, tmo ? "R6" : tag, "write count", wcnt, en);
        for (int i = 0; i < en && i < wcnt; i++) begin
            chk(wla[i] == ew_a[i], tag, $sformatf("write %0d addr", i), wla[i], ew_a[i]);
            chk(wld[i] == ew_d[i], tag, $sformatf("write %0d data", i), wld[i], ew_d[i]);
        end
        if (op == 2'd3) begin
            chk(id_word0 == ID0, "R4", "id word 0", id_word0, ID0);
            chk(id_word1 == ID1, "R4", "id word 1", id_word1, ID1);
            chk(rcnt == 2, "R4", "id read count", rcnt, 2);
        end else if (tmo) begin
            chk(rcnt == TMO, "R6", "poll reads before abort", rcnt, TMO);
        end else begin
            n = rcnt - ((op == 2'd0) ? 1 : 0);
            early = 0;
            for (int i = 0; i + 2 < n; i++) if (rld[i][6] == rld[i+1][6]) early = 1;
            chk(n >= 2 && rld[n-1][6] == rld[n-2][6] && !early, "R5",
                "poll stops at first equal bit-6 pair", n, 0);
        end
        @(negedge clk);
        chk(done == 1'b0, "R10", "done is one cycle", longint'(done), 0);
        chk(err == exp_err, "R10", "err held after done", longint'(err), longint'(exp_err));
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000 && !finished) begin @(posedge clk); cyc++; end
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(req_ready == 1'b1, "R9", "ready in reset", longint'(req_ready), 1);
        chk(done == 1'b0 && err == 1'b0, "R9", "done/err in reset", longint'({done, err}), 0);
        chk(fl_req == 1'b0, "R9", "bus idle in reset", longint'(fl_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fl_req == 1'b0 && req_ready == 1'b1, "R9", "idle after reset",
            longint'({fl_req, req_ready}), 1);

        // directed corners
        run_op(2'd3, 20'h00010, 16'h0000, 0);          // R4 identify
        run_op(2'd0, 20'h00013, 16'h0000, 0);          // R5 immediate completion
        run_op(2'd0, 20'h00012, 16'hFFFF, 3);          // R8 mismatch (word not erased)
        run_op(2'd1, 20'h00047, 16'h0000, 5);          // R2 sector erase
        run_op(2'd0, 20'h00042, 16'hA5C3, 2);          // R8 match on erased word
        run_op(2'd2, 20'h00000, 16'h0000, 1000);       // R6 timeout
        run_op(2'd0, 20'h00020, 16'h1234, 0);          // R8 err cleared by new request
        run_op(2'd2, 20'h00000, 16'h0000, 4);          // R3 chip erase

        // R7: request while busy is neither accepted nor queued
        busy_len = 8; wcnt = 0; rcnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd2; req_addr = 20'h0; req_data = '0;
        @(negedge clk);
        req_op = 2'd0; req_addr = 20'h00031; req_data = 16'h0F0F;
        for (int i = 0; i < 4; i++) begin
            chk(req_ready == 1'b0, "R7", "ready low while busy", longint'(req_ready), 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait_done();
        repeat (4) @(negedge clk);
        chk(wcnt == 6, "R7", "no extra writes from busy-time request", wcnt, 6);
        chk(fl_req == 1'b0, "R7", "bus quiet after done", longint'(fl_req), 0);

        // constrained random mix
        for (int k = 0; k < 30; k++) begin
            logic [1:0]  op = 2'($urandom_range(0, 3));
            logic [19:0] a  = {12'h000, 8'($urandom_range(0, 255))};
            logic [15:0] d  = 16'($urandom);
            int          bl = $urandom_range(0, 6);
            if ($urandom_range(0, 9) == 0) bl = 1000;
            run_op(op, a, d, bl);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule